// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Processor Core

This block is a processor core that carries out one instruction per clock cycle for a subset of the base 32-bit integer instruction set. It supports register-register and register-immediate arithmetic, logic, compare and shift operations. It also supports word loads and stores, the six conditional branches, and both jump-and-link forms. Each cycle the core presents the program counter on the instruction port and decodes the word that comes back. It reads two source registers, computes a result or an address, and optionally reads or writes the data port. The program counter, the register file and the data memory all take their new values on the next rising edge.

Both memories sit outside the core. They are modelled as ideal: a read returns data combinationally within the same cycle, and a write takes effect on the rising edge while the write enable is high. The core decodes the opcode with fixed combinational logic. Branch decisions and branch and jump targets come from a dedicated comparator and dedicated adders, so the ALU only serves arithmetic, logic and JALR target work. Opcodes the core does not support, including sub-word loads and stores, retire as no-ops that only move to the next word.

Top module: `rvsc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to 0x00000000 at the rising edge. While `rst` is high, `dmem_we` stays low and no register is written.
- R2: For opcode 0110011, funct3 and instruction bit 30 select one of ADD, SUB, SLL, SLT, SLTU, XOR, SRL, SRA, OR and AND. The sources are read from the registers named by bits 19:15 and 24:20, and the result is written to the register named by bits 11:7. Shift amounts use the low 5 bits of the second operand.
- R3: For opcode 0010011, the second operand is the sign-extended 12-bit immediate taken from bits 31:20. The shift forms use bits 24:20 as the amount, and bit 30 selects the arithmetic right shift.
- R4: A load (opcode 0000011, funct3 010) drives `dmem_addr` with rs1 plus the sign-extended 12-bit offset. It writes `dmem_rdata` to rd and keeps `dmem_we` low.
- R5: A store (opcode 0100011, funct3 010) raises `dmem_we`. It drives `dmem_addr` with rs1 plus the sign-extended split offset and `dmem_wdata` with rs2, and writes no register. The stored word is visible to a load in the next cycle.
- R6: A branch (opcode 1100011) uses funct3 to pick the condition: 000 for equal, 001 for not equal, 100 for signed less-than, 101 for signed greater-or-equal, 110 for unsigned less-than and 111 for unsigned greater-or-equal. When the condition holds, the next PC is PC plus the B-type offset; otherwise it is PC+4.
- R7: JAL (opcode 1101111) writes PC+4 to rd and sets the next PC to PC plus the J-type offset.
- R8: JALR (opcode 1100111, funct3 000) writes PC+4 to rd and sets the next PC to rs1 plus the I-type offset with bit 0 cleared. When rd equals rs1, the target uses the old value of rs1.
- R9: Register 0 always reads as zero, and writes to it have no effect.
- R10: Both read ports may name the same register in one cycle, and both then return its value.
- R11: Any unsupported encoding, including a load or store whose funct3 is not 010, only advances the PC by 4. It writes neither a register nor memory.
- R12: Every instruction retires in exactly one cycle: `imem_addr` takes a new value at each rising edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Fetch address (current PC) |
| imem_rdata | input | 32 | Instruction word returned combinationally |
| dmem_addr | output | 32 | Data address for loads and stores |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store enable, sampled by memory at the rising edge |
| dmem_rdata | input | 32 | Load data returned combinationally |

## Verification
The assertions check the following on every cycle: the reset value of the PC, zero reads from register 0 on both ports, and that unsupported encodings only step the PC. They also check that stores never write back, that a taken branch only comes from a branch opcode, and that a link write carries PC+4. Arithmetic results, branch directions, jump targets, load data and the order of writes across cycles can only be shown by the bench's instruction sequence. The bench reads results out through stores and follows the fetch address, so every register result is observed at the data port.

// File: rtl/rvsc_pkg.sv
package rvsc_pkg;

  localparam int XLEN = 32;

  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;

  localparam logic [2:0] F3_WORD = 3'b010;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND
  } alu_op_e;

  typedef enum logic {OPB_REG, OPB_IMM} opb_sel_e;
  typedef enum logic [1:0] {IMK_I, IMK_S, IMK_B, IMK_J} imm_kind_e;
  typedef enum logic [1:0] {WBS_ALU, WBS_MEM, WBS_LINK} wb_sel_e;
  typedef enum logic [1:0] {PCK_SEQ, PCK_BR, PCK_JAL, PCK_JALR} pc_kind_e;

  typedef struct packed {
    logic      legal;
    logic      rf_we;
    logic      mem_we;
    opb_sel_e  opb;
    imm_kind_e imk;
    alu_op_e   alu;
    wb_sel_e   wb;
    pc_kind_e  pck;
  } ctrl_t;

  // Immediate extraction, one function per format
  function automatic logic [XLEN-1:0] imm_i(input logic [31:0] w);
    return {{20{w[31]}}, w[31:20]};
  endfunction

  function automatic logic [XLEN-1:0] imm_s(input logic [31:0] w);
    return {{20{w[31]}}, w[31:25], w[11:7]};
  endfunction

  function automatic logic [XLEN-1:0] imm_b(input logic [31:0] w);
    return {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
  endfunction

  function automatic logic [XLEN-1:0] imm_j(input logic [31:0] w);
    return {{11{w[31]}}, w[31], w[19:12], w[20], w[30:21], 1'b0};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_op_e op,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [4:0] sh;
    sh = b[4:0];
    case (op)
      ALU_ADD:  return a + b;
      ALU_SUB:  return a - b;
      ALU_SLL:  return a << sh;
      ALU_SLT:  return {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
      ALU_SLTU: return {{(XLEN-1){1'b0}}, a < b};
      ALU_XOR:  return a ^ b;
      ALU_SRL:  return a >> sh;
      ALU_SRA:  return $unsigned($signed(a) >>> sh);
      ALU_OR:   return a | b;
      ALU_AND:  return a & b;
      default:  return '0;
    endcase
  endfunction

  // Branch condition from funct3 and the three comparator flags
  function automatic logic branch_cond(input logic [2:0] f3, input logic eq,
                                       input logic lt, input logic ltu);
    case (f3)
      3'b000:  return eq;
      3'b001:  return !eq;
      3'b100:  return lt;
      3'b101:  return !lt;
      3'b110:  return ltu;
      3'b111:  return !ltu;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/rvsc_decode.sv
module rvsc_decode
  import rvsc_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  input  logic [6:0] funct7,
  output ctrl_t      ctrl
);

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

  logic    alt_ok;
  logic    f7_base;
  alu_op_e arith_op;

  assign f7_base = (funct7 == F7_BASE);
  assign alt_ok  = (funct7 == F7_ALT);

  // funct3 to ALU operation; bit 30 picks SUB or SRA when allowed
  always_comb begin
    case (funct3)
      3'b000:  arith_op = ALU_ADD;
      3'b001:  arith_op = ALU_SLL;
      3'b010:  arith_op = ALU_SLT;
      3'b011:  arith_op = ALU_SLTU;
      3'b100:  arith_op = ALU_XOR;
      3'b101:  arith_op = alt_ok ? ALU_SRA : ALU_SRL;
      3'b110:  arith_op = ALU_OR;
      default: arith_op = ALU_AND;
    endcase
  end

  always_comb begin
    ctrl = '{legal: 1'b0, rf_we: 1'b0, mem_we: 1'b0, opb: OPB_REG,
             imk: IMK_I, alu: ALU_ADD, wb: WBS_ALU, pck: PCK_SEQ};
    case (opcode)
      OPC_REG: begin
        if (f7_base || (alt_ok && (funct3 == 3'b000 || funct3 == 3'b101))) begin
          ctrl.legal = 1'b1;
          ctrl.rf_we = 1'b1;
          ctrl.alu   = (funct3 == 3'b000 && alt_ok) ? ALU_SUB : arith_op;
        end
      end
      OPC_IMM: begin
        if ((funct3 != 3'b001 && funct3 != 3'b101) ||
            (funct3 == 3'b001 && f7_base) ||
            (funct3 == 3'b101 && (f7_base || alt_ok))) begin
          ctrl.legal = 1'b1;
          ctrl.rf_we = 1'b1;
          ctrl.opb   = OPB_IMM;
          ctrl.alu   = arith_op;
        end
      end
      OPC_LOAD: begin
        if (funct3 == F3_WORD) begin
          ctrl.legal = 1'b1;
          ctrl.rf_we = 1'b1;
          ctrl.opb   = OPB_IMM;
          ctrl.wb    = WBS_MEM;
        end
      end
      OPC_STORE: begin
        if (funct3 == F3_WORD) begin
          ctrl.legal  = 1'b1;
          ctrl.mem_we = 1'b1;
          ctrl.opb    = OPB_IMM;
          ctrl.imk    = IMK_S;
        end
      end
      OPC_BRANCH: begin
        if (funct3 != 3'b010 && funct3 != 3'b011) begin
          ctrl.legal = 1'b1;
          ctrl.imk   = IMK_B;
          ctrl.pck   = PCK_BR;
        end
      end
      OPC_JAL: begin
        ctrl.legal = 1'b1;
        ctrl.rf_we = 1'b1;
        ctrl.imk   = IMK_J;
        ctrl.wb    = WBS_LINK;
        ctrl.pck   = PCK_JAL;
      end
      OPC_JALR: begin
        if (funct3 == 3'b000) begin
          ctrl.legal = 1'b1;
          ctrl.rf_we = 1'b1;
          ctrl.opb   = OPB_IMM;
          ctrl.wb    = WBS_LINK;
          ctrl.pck   = PCK_JALR;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rvsc_regfile.sv
module rvsc_regfile #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr_a,
  output logic [WIDTH-1:0] rdata_a,
  input  logic [AW-1:0]    raddr_b,
  output logic [WIDTH-1:0] rdata_b
);

  logic [WIDTH-1:0] store [DEPTH];

  // Entry 0 is never written; reads of it are forced to zero below
  always_ff @(posedge clk) begin
    if (we && waddr != '0) store[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : store[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : store[raddr_b];

endmodule

// File: rtl/rvsc_alu.sv
module rvsc_alu
  import rvsc_pkg::*;
(
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);

  assign y = alu_eval(op, a, b);

endmodule

// File: rtl/rvsc_brcomp.sv
module rvsc_brcomp #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             eq,
  output logic             lt,
  output logic             ltu
);

  assign eq  = (a == b);
  assign lt  = ($signed(a) < $signed(b));
  assign ltu = (a < b);

endmodule

// File: rtl/rvsc_core.sv
module rvsc_core
  import rvsc_pkg::*;
#(
  parameter logic [31:0] RESET_PC  = 32'h0000_0000,
  parameter int          REG_COUNT = 32
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);

  localparam int RA_W = $clog2(REG_COUNT);

  // Named internal events, exposed for the bound checker
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] pc_next;
  logic [XLEN-1:0] pc_plus4;
  logic [31:0]     instr;
  ctrl_t           ctrl;
  logic            illegal;
  logic [RA_W-1:0] rs1_addr;
  logic [RA_W-1:0] rs2_addr;
  logic [RA_W-1:0] rf_waddr;
  logic [XLEN-1:0] rs1_data;
  logic [XLEN-1:0] rs2_data;
  logic [XLEN-1:0] rf_wdata;
  logic            rf_we;
  logic [XLEN-1:0] imm;
  logic [XLEN-1:0] opb;
  logic [XLEN-1:0] alu_y;
  logic            cmp_eq;
  logic            cmp_lt;
  logic            cmp_ltu;
  logic            br_taken;

  assign instr     = imem_rdata;
  assign imem_addr = pc_q;
  assign pc_plus4  = pc_q + 32'd4;
  assign rs1_addr  = instr[15 +: RA_W];
  assign rs2_addr  = instr[20 +: RA_W];
  assign rf_waddr  = instr[7 +: RA_W];

  rvsc_decode u_dec (
    .opcode (instr[6:0]),
    .funct3 (instr[14:12]),
    .funct7 (instr[31:25]),
    .ctrl   (ctrl)
  );

  assign illegal = !ctrl.legal;

  rvsc_regfile #(.WIDTH(XLEN), .DEPTH(REG_COUNT)) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (rs1_addr),
    .rdata_a (rs1_data),
    .raddr_b (rs2_addr),
    .rdata_b (rs2_data)
  );

  // Immediate select by instruction format
  always_comb begin
    case (ctrl.imk)
      IMK_S:   imm = imm_s(instr);
      IMK_B:   imm = imm_b(instr);
      IMK_J:   imm = imm_j(instr);
      default: imm = imm_i(instr);
    endcase
  end

  assign opb = (ctrl.opb == OPB_IMM) ? imm : rs2_data;

  rvsc_alu u_alu (
    .op (ctrl.alu),
    .a  (rs1_data),
    .b  (opb),
    .y  (alu_y)
  );

  rvsc_brcomp #(.WIDTH(XLEN)) u_cmp (
    .a   (rs1_data),
    .b   (rs2_data),
    .eq  (cmp_eq),
    .lt  (cmp_lt),
    .ltu (cmp_ltu)
  );

  assign br_taken = (ctrl.pck == PCK_BR) &&
                    branch_cond(instr[14:12], cmp_eq, cmp_lt, cmp_ltu);

  // Write-back select
  always_comb begin
    case (ctrl.wb)
      WBS_MEM:  rf_wdata = dmem_rdata;
      WBS_LINK: rf_wdata = pc_plus4;
      default:  rf_wdata = alu_y;
    endcase
  end

  assign rf_we      = ctrl.rf_we && !rst;
  assign dmem_we    = ctrl.mem_we && !rst;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rs2_data;

  // Next-PC select; branch and jump targets use their own adders
  always_comb begin
    case (ctrl.pck)
      PCK_BR:   pc_next = br_taken ? (pc_q + imm) : pc_plus4;
      PCK_JAL:  pc_next = pc_q + imm;
      PCK_JALR: pc_next = {alu_y[XLEN-1:1], 1'b0};
      default:  pc_next = pc_plus4;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_next;
  end

endmodule

// File: rtl/rvsc_core_chk.sv
module rvsc_core_chk
  import rvsc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  parameter int          RA_W     = 5
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] pc_q,
  input logic [XLEN-1:0] pc_next,
  input logic [31:0]     instr,
  input logic            illegal,
  input logic            rf_we,
  input logic [XLEN-1:0] rf_wdata,
  input logic [RA_W-1:0] rs1_addr,
  input logic [XLEN-1:0] rs1_data,
  input logic [RA_W-1:0] rs2_addr,
  input logic [XLEN-1:0] rs2_data,
  input logic            dmem_we,
  input logic            br_taken
);

  logic [6:0] opc;
  assign opc = instr[6:0];

  // R1
  reset_pc_chk: assert property (@(posedge clk) rst |=> (pc_q == RESET_PC));

  // R9
  zero_read_a_chk: assert property (@(posedge clk) disable iff (rst)
    (rs1_addr == '0) |-> (rs1_data == '0));

  // R9
  zero_read_b_chk: assert property (@(posedge clk) disable iff (rst)
    (rs2_addr == '0) |-> (rs2_data == '0));

  // R11
  illegal_noop_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!rf_we && !dmem_we && pc_next == pc_q + 32'd4));

  // R5
  store_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (!rf_we && opc == OPC_STORE));

  // R6
  taken_src_chk: assert property (@(posedge clk) disable iff (rst)
    br_taken |-> (opc == OPC_BRANCH));

  // R6
  not_taken_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == OPC_BRANCH && !br_taken) |-> (pc_next == pc_q + 32'd4));

  // R7
  link_value_chk: assert property (@(posedge clk) disable iff (rst)
    ((opc == OPC_JAL || opc == OPC_JALR) && rf_we) |-> (rf_wdata == pc_q + 32'd4));

endmodule

bind rvsc_core rvsc_core_chk #(.RESET_PC(RESET_PC), .RA_W(RA_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .pc_q     (pc_q),
  .pc_next  (pc_next),
  .instr    (instr),
  .illegal  (illegal),
  .rf_we    (rf_we),
  .rf_wdata (rf_wdata),
  .rs1_addr (rs1_addr),
  .rs1_data (rs1_data),
  .rs2_addr (rs2_addr),
  .rs2_data (rs2_data),
  .dmem_we  (dmem_we),
  .br_taken (br_taken)
);

// File: tb/rvsc_core_tb_top.sv
module rvsc_core_tb_top;

  localparam int WATCHDOG_CYC = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr;
  logic [31:0] imem_rdata;
  logic [31:0] dmem_addr;
  logic [31:0] dmem_wdata;
  logic        dmem_we;
  logic [31:0] dmem_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  rvsc_core dut_i (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  // Ideal data memory: combinational read, write at the rising edge
  logic [31:0] dmem [64];
  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
  assign dmem_rdata = (dmem_addr == 32'd40) ? 32'h1234_5678 : dmem[dmem_addr[7:2]];

  // Instruction encoders
  function automatic logic [31:0] e_r(int f7, int rs2, int rs1, int f3, int rd);
    return {7'(f7), 5'(rs2), 5'(rs1), 3'(f3), 5'(rd), 7'b0110011};
  endfunction
  function automatic logic [31:0] e_i(int imm, int rs1, int f3, int rd, logic [6:0] opc);
    return {12'(imm), 5'(rs1), 3'(f3), 5'(rd), opc};
  endfunction
  function automatic logic [31:0] e_s(int imm, int rs2, int rs1);
    logic [11:0] v;
    v = 12'(imm);
    return {v[11:5], 5'(rs2), 5'(rs1), 3'b010, v[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] e_b(int imm, int rs2, int rs1, int f3);
    logic [12:0] v;
    v = 13'(imm);
    return {v[12], v[10:5], 5'(rs2), 5'(rs1), 3'(f3), v[4:1], v[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] e_j(int imm, int rd);
    logic [20:0] v;
    v = 21'(imm);
    return {v[20], v[10:1], v[11], v[19:12], 5'(rd), 7'b1101111};
  endfunction

  localparam logic [6:0] OI = 7'b0010011;
  localparam logic [6:0] OL = 7'b0000011;
  localparam logic [6:0] OJR = 7'b1100111;

  typedef struct packed {
    logic [3:0]  rq;
    logic [31:0] pc;
    logic [31:0] ins;
    logic        we;
    logic [31:0] addr;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 52;
  localparam vec_t VECS [NV] = '{
    '{4'd3,  32'd0,   e_i(5, 0, 0, 1, OI),          1'b0, 32'd0,  32'd0},          // R3 x1=5
    '{4'd3,  32'd4,   e_i(-3, 0, 0, 2, OI),         1'b0, 32'd0,  32'd0},          // R3 x2=-3
    '{4'd2,  32'd8,   e_r(0, 2, 1, 0, 3),           1'b0, 32'd0,  32'd0},          // R2 ADD
    '{4'd5,  32'd12,  e_s(0, 3, 0),                 1'b1, 32'd0,  32'd2},          // R5
    '{4'd2,  32'd16,  e_r(32, 2, 1, 0, 4),          1'b0, 32'd0,  32'd0},          // R2 SUB
    '{4'd2,  32'd20,  e_s(4, 4, 0),                 1'b1, 32'd4,  32'd8},
    '{4'd2,  32'd24,  e_r(0, 1, 2, 2, 5),           1'b0, 32'd0,  32'd0},          // R2 SLT
    '{4'd2,  32'd28,  e_r(0, 1, 2, 3, 6),           1'b0, 32'd0,  32'd0},          // R2 SLTU
    '{4'd2,  32'd32,  e_s(8, 5, 0),                 1'b1, 32'd8,  32'd1},
    '{4'd2,  32'd36,  e_s(12, 6, 0),                1'b1, 32'd12, 32'd0},
    '{4'd3,  32'd40,  e_i(12'h401, 2, 5, 7, OI),    1'b0, 32'd0,  32'd0},          // R3 SRAI
    '{4'd3,  32'd44,  e_i(28, 2, 5, 8, OI),         1'b0, 32'd0,  32'd0},          // R3 SRLI
    '{4'd3,  32'd48,  e_s(16, 7, 0),                1'b1, 32'd16, 32'hFFFF_FFFE},
    '{4'd3,  32'd52,  e_s(20, 8, 0),                1'b1, 32'd20, 32'h0000_000F},
    '{4'd2,  32'd56,  e_r(0, 2, 1, 4, 9),           1'b0, 32'd0,  32'd0},          // R2 XOR
    '{4'd2,  32'd60,  e_s(24, 9, 0),                1'b1, 32'd24, 32'hFFFF_FFF8},
    '{4'd2,  32'd64,  e_r(0, 1, 1, 1, 10),          1'b0, 32'd0,  32'd0},          // R2 SLL
    '{4'd2,  32'd68,  e_s(28, 10, 0),               1'b1, 32'd28, 32'h0000_00A0},
    '{4'd3,  32'd72,  e_i(12'h0F0, 2, 7, 11, OI),   1'b0, 32'd0,  32'd0},          // R3 ANDI
    '{4'd3,  32'd76,  e_s(32, 11, 0),               1'b1, 32'd32, 32'h0000_00F0},
    '{4'd4,  32'd80,  e_i(40, 0, 2, 12, OL),        1'b0, 32'd0,  32'd0},          // R4 LW
    '{4'd4,  32'd84,  e_s(44, 12, 0),               1'b1, 32'd44, 32'h1234_5678},
    '{4'd9,  32'd88,  e_i(7, 0, 0, 0, OI),          1'b0, 32'd0,  32'd0},          // R9 write x0
    '{4'd9,  32'd92,  e_s(48, 0, 0),                1'b1, 32'd48, 32'd0},
    '{4'd10, 32'd96,  e_r(0, 1, 1, 0, 13),          1'b0, 32'd0,  32'd0},          // R10 same reg
    '{4'd10, 32'd100, e_s(52, 13, 0),               1'b1, 32'd52, 32'd10},
    '{4'd6,  32'd104, e_b(8, 1, 1, 0),              1'b0, 32'd0,  32'd0},          // R6 BEQ taken
    '{4'd6,  32'd112, e_b(8, 1, 1, 1),              1'b0, 32'd0,  32'd0},          // R6 BNE not
    '{4'd6,  32'd116, e_b(8, 1, 2, 4),              1'b0, 32'd0,  32'd0},          // R6 BLT taken
    '{4'd6,  32'd124, e_b(8, 1, 2, 6),              1'b0, 32'd0,  32'd0},          // R6 BLTU not
    '{4'd6,  32'd128, e_b(12, 2, 1, 5),             1'b0, 32'd0,  32'd0},          // R6 BGE taken
    '{4'd6,  32'd140, e_b(-8, 1, 2, 7),             1'b0, 32'd0,  32'd0},          // R6 BGEU back
    '{4'd6,  32'd132, e_b(16, 0, 0, 0),             1'b0, 32'd0,  32'd0},          // R6
    '{4'd7,  32'd148, e_j(12, 14),                  1'b0, 32'd0,  32'd0},          // R7 JAL
    '{4'd7,  32'd160, e_s(56, 14, 0),               1'b1, 32'd56, 32'd152},
    '{4'd8,  32'd164, e_i(5, 14, 0, 15, OJR),       1'b0, 32'd0,  32'd0},          // R8 JALR
    '{4'd8,  32'd156, e_s(60, 15, 0),               1'b1, 32'd60, 32'd168},
    '{4'd11, 32'd160, 32'h0000_008B,                1'b0, 32'd0,  32'd0},          // R11 unsupported
    '{4'd11, 32'd164, e_s(64, 1, 0),                1'b1, 32'd64, 32'd5},
    '{4'd8,  32'd168, e_i(200, 1, 0, 1, OJR),       1'b0, 32'd0,  32'd0},          // R8 rd==rs1
    '{4'd8,  32'd204, e_s(68, 1, 0),                1'b1, 32'd68, 32'd172},
    '{4'd6,  32'd208, e_b(8, 2, 1, 4),              1'b0, 32'd0,  32'd0},          // R6 BLT not
    '{4'd3,  32'd212, e_i(-2, 2, 2, 16, OI),        1'b0, 32'd0,  32'd0},          // R3 SLTI
    '{4'd3,  32'd216, e_s(72, 16, 0),               1'b1, 32'd72, 32'd1},
    '{4'd2,  32'd220, e_r(32, 1, 2, 5, 18),         1'b0, 32'd0,  32'd0},          // R2 SRA
    '{4'd2,  32'd224, e_s(76, 18, 0),               1'b1, 32'd76, 32'hFFFF_FFFF},
    '{4'd2,  32'd228, e_r(0, 13, 1, 6, 19),         1'b0, 32'd0,  32'd0},          // R2 OR
    '{4'd2,  32'd232, e_s(80, 19, 0),               1'b1, 32'd80, 32'h0000_00AE},
    '{4'd2,  32'd236, e_r(0, 13, 2, 5, 20),         1'b0, 32'd0,  32'd0},          // R2 SRL
    '{4'd2,  32'd240, e_s(84, 20, 0),               1'b1, 32'd84, 32'h003F_FFFF},
    '{4'd2,  32'd244, e_r(0, 1, 2, 7, 21),          1'b0, 32'd0,  32'd0},          // R2 AND
    '{4'd2,  32'd248, e_s(88, 21, 0),               1'b1, 32'd88, 32'h0000_00AC}
  };

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // Called just after a falling edge; checks, then waits for the next one
  task automatic step(input logic [31:0] ins, input logic [31:0] xpc, input logic xwe,
                      input logic [31:0] xa, input logic [31:0] xd, input string rq);
    imem_rdata = ins;
    #1;
    check(rq, "pc (R12)", imem_addr, xpc);
    check(rq, "dmem_we", {31'd0, dmem_we}, {31'd0, xwe});
    if (xwe) begin
      check(rq, "dmem_addr", dmem_addr, xa);
      check(rq, "dmem_wdata", dmem_wdata, xd);
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    imem_rdata = e_i(0, 0, 0, 0, OI);
    repeat (2) @(negedge clk);
    #1;
    check("R1", "reset pc", imem_addr, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < NV; k++)
      step(VECS[k].ins, VECS[k].pc, VECS[k].we, VECS[k].addr, VECS[k].data,
           $sformatf("R%0d", VECS[k].rq));
    // R11: sub-word load is a no-op, x1 keeps 172
    step(e_i(0, 0, 0, 1, OL), 32'd252, 1'b0, 32'd0, 32'd0, "R11");
    step(e_s(92, 1, 0), 32'd256, 1'b1, 32'd92, 32'd172, "R11");
    // R4/R5: word stored at address 0 earlier reads back
    step(e_i(0, 0, 2, 22, OL), 32'd260, 1'b0, 32'd0, 32'd0, "R4");
    step(e_s(96, 22, 0), 32'd264, 1'b1, 32'd96, 32'd2, "R5");
    // R1: reset mid-run blocks stores and returns the PC to zero
    rst = 1'b1;
    imem_rdata = e_s(0, 1, 0);
    #1;
    check("R1", "store during reset", {31'd0, dmem_we}, 32'd0);
    @(negedge clk);
    #1;
    check("R1", "pc after reset", imem_addr, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    step(e_i(0, 0, 0, 0, OI), 32'd0, 1'b0, 32'd0, 32'd0, "R1");
    step(e_s(100, 1, 0), 32'd4, 1'b1, 32'd100, 32'd172, "R1");
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

endmodule